// File: doc/BRIEF.md
# Scratchpad Line Arbiter with Burst Prefetch

This block sits in front of a private single-port scratchpad made of 16-byte lines. Three clients compete for the memory: a DMA engine, the core's load/store path and an instruction prefetcher. A fixed-priority arbiter grants exactly one of them per cycle. A DMA or load/store access moves one whole line. Any of them may write. Byte addresses are accepted, but the four lowest bits play no part, so even a single scalar occupies a full line.

A prefetch is an eight-line burst. A pulse on the prefetch request while no burst is active arms a small state machine. It has two states: `BURST_IDLE` and `BURST_RUN`. The transition `BURST_IDLE -> BURST_RUN` is taken on the pulse; the start line and the force flag are captured at that point. In `BURST_RUN` the machine offers one line per cycle to the arbiter and counts only the lines that are granted. The transition `BURST_RUN -> BURST_IDLE` is taken on the grant of the eighth line. A higher-priority client can pre-empt the burst between lines, and the burst then resumes at the line it had not yet received. When the force flag is captured with the burst, the burst ranks above load/store; it never ranks above DMA.

Read data returns a fixed two cycles after the grant, with a tag that names the client. No access can fault. Within a line, byte offset 0 is carried on the most significant byte of the data word.

Top module: `scratch_arb`

## Requirements
- R1: While reset is held and directly after it is released, all three grants are low, `rd_valid` is low and `pf_busy` is low.
- R2: At most one grant is high in any cycle. A DMA request is always granted in the cycle it is presented.
- R3: A load/store request is granted in the same cycle when there is no DMA request and no forced burst is running. It loses to DMA.
- R4: A prefetch line is granted only in cycles with no DMA request. An unforced burst also needs the cycle to have no load/store request.
- R5: The line index is address bits [14:4]. Bits [3:0] are ignored, so any two byte addresses that differ only in those bits reach the same 128-bit line.
- R6: A granted write stores the full line. A granted read raises `rd_valid` exactly two cycles later, with that line's data and the tag 0 for DMA, 1 for load/store or 2 for prefetch. A write never raises `rd_valid`.
- R7: With no burst active, a `pf_req` pulse raises `pf_busy` from the next cycle on. The burst then delivers 8 consecutive lines starting at the line of `pf_addr`, wrapping modulo 2048 lines. `pf_busy` falls in the cycle after the eighth line is granted.
- R8: A burst pre-empted for one or more cycles skips no line and repeats no line. It resumes with the next line it has not yet delivered.
- R9: `pf_force` high with the starting `pf_req` makes the whole burst win over load/store requests. A DMA request still wins over the burst.
- R10: A `pf_req` while `pf_busy` is high is ignored. The running burst keeps its line sequence and ends after its eighth line, and no second burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 15 | DMA byte address |
| dma_wdata | input | 128 | DMA write line |
| ldst_req | input | 1 | Load/store access request |
| ldst_we | input | 1 | Store (1) or load (0) |
| ldst_addr | input | 15 | Load/store byte address |
| ldst_wdata | input | 128 | Store line |
| pf_req | input | 1 | Start-of-burst pulse for prefetch |
| pf_force | input | 1 | Forces the starting burst above load/store |
| pf_addr | input | 15 | Byte address of the first burst line |
| dma_gnt | output | 1 | DMA granted this cycle |
| ldst_gnt | output | 1 | Load/store granted this cycle |
| pf_gnt | output | 1 | A prefetch line granted this cycle |
| pf_busy | output | 1 | A burst is in progress |
| rd_valid | output | 1 | Read data valid |
| rd_tag | output | 2 | Client that issued the read |
| rd_data | output | 128 | Returned line |

## Verification
The interesting collision is a load/store request that arrives in the same cycle as a pending burst line, sometimes with a DMA request on top. The directed tests hold load/store or DMA high partway through unforced and forced bursts. One of these bursts starts near the top line so that its sequence wraps. In every cycle the bench compares the grant pattern with the priority it expects. Two cycles later it compares the returned tag and line against its own memory model. This shows that a pre-empted line is delivered later, that the burst does not advance past it, and that the other client's read comes back correctly interleaved with the burst's reads.

// File: rtl/scratch_arb_pkg.sv
package scratch_arb_pkg;

    typedef enum logic [1:0] {
        SRC_DMA  = 2'd0,
        SRC_LDST = 2'd1,
        SRC_PF   = 2'd2
    } src_e;

    typedef enum logic {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_e;

endpackage

// File: rtl/scratch_arb_burst.sv
module scratch_arb_burst
    import scratch_arb_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int BEATS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              start_force,
    input  logic [LINE_W-1:0] start_line,
    input  logic              beat_gnt,
    output logic              busy,
    output logic              forced,
    output logic [LINE_W-1:0] cur_line
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    burst_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [LINE_W-1:0] base_q;
    logic              force_q;

    // state register and burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BURST_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            force_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                BURST_IDLE: begin
                    if (start_req) begin
                        base_q  <= start_line;
                        force_q <= start_force;
                        cnt_q   <= '0;
                    end
                end
                BURST_RUN: begin
                    if (beat_gnt) begin
                        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BURST_IDLE: if (start_req) state_d = BURST_RUN;
            BURST_RUN:  if (beat_gnt && cnt_q == LAST) state_d = BURST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q == BURST_RUN);
        forced   = busy && force_q;
        cur_line = base_q + LINE_W'(cnt_q);
    end

    // R7
    beat_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_gnt |-> busy);

    // R8
    hold_on_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_gnt) |=> (busy && $stable(cur_line)));

    // R10
    ignore_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && !beat_gnt) |=> $stable(cur_line));

endmodule

// File: rtl/scratch_arb_store.sv
module scratch_arb_store
    import scratch_arb_pkg::*;
#(
    parameter int LINES  = 2048,
    parameter int DATA_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     we,
    input  logic [$clog2(LINES)-1:0] line,
    input  logic [DATA_W-1:0]        wdata,
    input  src_e                     tag_in,
    output logic                     rd_valid,
    output src_e                     rd_tag,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DATA_W-1:0] mem [LINES];

    logic              s1_v, s2_v;
    src_e              s1_t, s2_t;
    logic [DATA_W-1:0] s1_d, s2_d;

    always_ff @(posedge clk) begin
        if (en && we) mem[line] <= wdata;
    end

    always_ff @(posedge clk) begin
        s1_d <= mem[line];
        s2_d <= s1_d;
        s1_t <= tag_in;
        s2_t <= s1_t;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
        end else begin
            s1_v <= en && !we;
            s2_v <= s1_v;
        end
    end

    assign rd_valid = s2_v;
    assign rd_tag   = s2_t;
    assign rd_data  = s2_d;

    // R6
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> ##1 rd_valid);

    // R6
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> ##1 !rd_valid);

endmodule

// File: rtl/scratch_arb.sv
module scratch_arb
    import scratch_arb_pkg::*;
#(
    parameter int LINES  = 2048,
    parameter int DATA_W = 128,
    parameter int BEATS  = 8,
    parameter int LINE_W = $clog2(LINES),
    parameter int ADDR_W = LINE_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              ldst_req,
    input  logic              ldst_we,
    input  logic [ADDR_W-1:0] ldst_addr,
    input  logic [DATA_W-1:0] ldst_wdata,
    input  logic              pf_req,
    input  logic              pf_force,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              dma_gnt,
    output logic              ldst_gnt,
    output logic              pf_gnt,
    output logic              pf_busy,
    output logic              rd_valid,
    output logic [1:0]        rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic              pf_forced;
    logic [LINE_W-1:0] pf_line;
    logic              m_en, m_we;
    logic [LINE_W-1:0] m_line;
    logic [DATA_W-1:0] m_wdata;
    src_e              m_tag, r_tag;

    scratch_arb_burst #(.LINE_W(LINE_W), .BEATS(BEATS)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (pf_req),
        .start_force(pf_force),
        .start_line (pf_addr[ADDR_W-1:4]),
        .beat_gnt   (pf_gnt),
        .busy       (pf_busy),
        .forced     (pf_forced),
        .cur_line   (pf_line)
    );

    // fixed priority: DMA, then (forced burst | load/store), then burst
    always_comb begin
        dma_gnt  = dma_req;
        ldst_gnt = ldst_req && !dma_req && !pf_forced;
        pf_gnt   = pf_busy && !dma_req && (pf_forced || !ldst_req);
    end

    always_comb begin
        m_en    = dma_gnt || ldst_gnt || pf_gnt;
        m_we    = 1'b0;
        m_line  = pf_line;
        m_wdata = dma_wdata;
        m_tag   = SRC_PF;
        if (dma_gnt) begin
            m_we   = dma_we;
            m_line = dma_addr[ADDR_W-1:4];
            m_tag  = SRC_DMA;
        end else if (ldst_gnt) begin
            m_we    = ldst_we;
            m_line  = ldst_addr[ADDR_W-1:4];
            m_wdata = ldst_wdata;
            m_tag   = SRC_LDST;
        end
    end

    scratch_arb_store #(.LINES(LINES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (m_en),
        .we      (m_we),
        .line    (m_line),
        .wdata   (m_wdata),
        .tag_in  (m_tag),
        .rd_valid(rd_valid),
        .rd_tag  (r_tag),
        .rd_data (rd_data)
    );

    assign rd_tag = r_tag;

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_gnt, ldst_gnt, pf_gnt}));

    // R2
    dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dma_gnt);

    // R3
    ldst_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ldst_req && !dma_req && !pf_busy) |-> ldst_gnt);

    // R9
    forced_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_busy && pf_force && $rose(pf_busy) && ldst_req && !dma_req) |-> pf_gnt);

    // R4
    pf_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_gnt |-> !dma_req);

endmodule

// File: tb/scratch_arb_bench.sv
module scratch_arb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 11;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dma_req = 0, dma_we = 0, ldst_req = 0, ldst_we = 0;
    logic          pf_req = 0, pf_force = 0;
    logic [AW-1:0] dma_addr = '0, ldst_addr = '0, pf_addr = '0;
    logic [127:0]  dma_wdata = '0, ldst_wdata = '0;
    logic          dma_gnt, ldst_gnt, pf_gnt, pf_busy, rd_valid;
    logic [1:0]    rd_tag;
    logic [127:0]  rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [127:0]  model [2048];
    logic [LW-1:0] exp_pf_line;
    logic          e1_v = 0, e2_v = 0;
    logic [1:0]    e1_t = 0, e2_t = 0;
    logic [127:0]  e1_d = '0, e2_d = '0;

    scratch_arb u_scratch_arb (
        .clk(clk), .rst_n(rst_n),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .ldst_req(ldst_req), .ldst_we(ldst_we), .ldst_addr(ldst_addr), .ldst_wdata(ldst_wdata),
        .pf_req(pf_req), .pf_force(pf_force), .pf_addr(pf_addr),
        .dma_gnt(dma_gnt), .ldst_gnt(ldst_gnt), .pf_gnt(pf_gnt), .pf_busy(pf_busy),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] pat(input int l, input int salt);
        return {4{16'(l) ^ 16'h5A3C, 16'(l * 7 + salt)}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge with inputs already set; leaves at the next negedge
    task automatic step(input bit xd, input bit xl, input bit xp, input string req);
        logic         nv;
        logic [1:0]   nt;
        logic [127:0] nd;
        #1;
        chk({dma_gnt, ldst_gnt, pf_gnt} === {xd, xl, xp}, req,
            128'({dma_gnt, ldst_gnt, pf_gnt}), 128'({xd, xl, xp}));
        nv = 0; nt = 0; nd = '0;
        if (xd) begin
            if (dma_we) model[dma_addr[AW-1:4]] = dma_wdata;
            else begin nv = 1; nt = 2'd0; nd = model[dma_addr[AW-1:4]]; end
        end else if (xl) begin
            if (ldst_we) model[ldst_addr[AW-1:4]] = ldst_wdata;
            else begin nv = 1; nt = 2'd1; nd = model[ldst_addr[AW-1:4]]; end
        end else if (xp) begin
            nv = 1; nt = 2'd2; nd = model[exp_pf_line];
            exp_pf_line = exp_pf_line + 1'b1;
        end
        // R6: read return two cycles after its grant
        chk(rd_valid === e2_v && (!e2_v || (rd_tag === e2_t && rd_data === e2_d)),
            {req, " R6 return"}, e2_v ? rd_data : 128'(rd_valid), e2_v ? e2_d : 128'(e2_v));
        e2_v = e1_v; e2_t = e1_t; e2_d = e1_d;
        e1_v = nv;   e1_t = nt;   e1_d = nd;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        dma_req = 0; ldst_req = 0; pf_req = 0; pf_force = 0;
        for (int i = 0; i < n; i++) step(0, 0, 0, req);
    endtask

    task automatic t_reset;
        #1;
        chk({dma_gnt, ldst_gnt, pf_gnt, rd_valid, pf_busy} === 5'b0, "R1",
            128'({dma_gnt, ldst_gnt, pf_gnt, rd_valid, pf_busy}), 128'(0));
    endtask

    task automatic t_fill;
        for (int i = 0; i < 24; i++) begin
            int l = (i < 16) ? i : 2024 + i;
            dma_req = 1; dma_we = 1;
            dma_addr = {LW'(l), 4'(i * 3)};
            dma_wdata = pat(l, 1);
            step(1, 0, 0, "R2 dma write");
        end
        dma_we = 0;
        idle(2, "R6 write no return");
    endtask

    task automatic t_addr_ignore;
        // R5: write via offset 5, read via offset F of the same line
        ldst_req = 1; ldst_we = 1; ldst_addr = {LW'(6), 4'h5}; ldst_wdata = pat(6, 99);
        step(0, 1, 0, "R5 store");
        ldst_we = 0; ldst_addr = {LW'(6), 4'hF};
        step(0, 1, 0, "R5 load");
        ldst_req = 0; dma_req = 1; dma_we = 0; dma_addr = {LW'(6), 4'h0};
        step(1, 0, 0, "R5 dma load");
        idle(3, "R6");
    endtask

    task automatic t_priority;
        dma_req = 1; dma_we = 0; dma_addr = {LW'(2), 4'h0};
        ldst_req = 1; ldst_we = 0; ldst_addr = {LW'(3), 4'h8};
        step(1, 0, 0, "R2 dma over ldst");
        dma_req = 0;
        step(0, 1, 0, "R3 ldst after dma");
        idle(3, "R6");
    endtask

    task automatic t_burst;
        pf_req = 1; pf_addr = {LW'(8), 4'h7}; exp_pf_line = LW'(8);
        step(0, 0, 0, "R7 accept");
        pf_req = 0;
        chk(pf_busy === 1'b1, "R7 busy", 128'(pf_busy), 128'(1));
        for (int i = 0; i < 8; i++) step(0, 0, 1, "R7 beat");
        #1;
        chk(pf_busy === 1'b0, "R7 end", 128'(pf_busy), 128'(0));
        idle(3, "R6");
    endtask

    task automatic t_preempt;
        pf_req = 1; pf_addr = {LW'(0), 4'h0}; exp_pf_line = '0;
        step(0, 0, 0, "R7 accept");
        pf_req = 0;
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R8 beat");
        ldst_req = 1; ldst_we = 0; ldst_addr = {LW'(12), 4'h1};
        pf_req = 1; pf_addr = {LW'(13), 4'h0};
        step(0, 1, 0, "R4 ldst over burst");
        pf_req = 0;
        step(0, 1, 0, "R4 ldst over burst");
        ldst_req = 0; dma_req = 1; dma_we = 0; dma_addr = {LW'(14), 4'h0};
        step(1, 0, 0, "R4 dma over burst");
        dma_req = 0;
        for (int i = 0; i < 5; i++) step(0, 0, 1, "R8 resume");
        #1;
        chk(pf_busy === 1'b0, "R10 no second burst", 128'(pf_busy), 128'(0));
        idle(3, "R10");
    endtask

    task automatic t_force_wrap;
        ldst_req = 1; ldst_we = 0; ldst_addr = {LW'(9), 4'h0};
        pf_req = 1; pf_force = 1; pf_addr = {LW'(2044), 4'hC}; exp_pf_line = LW'(2044);
        step(0, 1, 0, "R9 idle accept");
        pf_req = 0; pf_force = 0;
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R9 forced beat");
        dma_req = 1; dma_we = 0; dma_addr = {LW'(1), 4'h0};
        step(1, 0, 0, "R9 dma over forced");
        dma_req = 0;
        for (int i = 0; i < 5; i++) step(0, 0, 1, "R7 wrap beat");
        step(0, 1, 0, "R3 ldst after burst");
        idle(3, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_reset;
        t_fill;
        t_addr_ignore;
        t_priority;
        t_burst;
        t_preempt;
        t_force_wrap;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule